// File: doc/BRIEF.md
# Two-Level Page-Table Walker with Large-Page Support

This block translates a 32-bit virtual address into a 32-bit physical address by walking a two-level page table held in memory. A client presents a virtual address together with the directory base register value while the walker is idle. The walker then fetches one directory entry and, when that entry maps a small page, one table entry. Each fetch is a 32-bit word read over a request/response handshake that tolerates any number of wait cycles. When the walk ends, the walker raises a one-cycle done pulse and presents either the translated address or a fault.

Bit 0 of every entry is the present flag, and bit 7 of a directory entry is the page-size flag. A set size flag ends the walk after the directory read. The block then maps a 4 MB region whose frame is the top 10 bits of the directory entry, and it skips the table read. A cleared size flag selects a 4 KB page. In that case the directory entry's top 20 bits locate the page table, and the table entry's top 20 bits supply the frame.

Top module: `page_walker`

## Requirements
- R1: While reset is asserted, and once it is released, req_ready is 1 and mem_rd_valid, done and fault are 0.
- R2: The cycle after a request is accepted, mem_rd_valid is 1 and mem_rd_addr = {base[31:12], va[31:22], 2'b00}. The base and the va are those sampled when the request was accepted, and base bits 11:0 are ignored.
- R3: A memory read holds mem_rd_valid at 1 and mem_rd_addr stable until a cycle with mem_rsp_valid = 1, for any number of wait cycles.
- R4: A directory entry with bit 0 = 0 ends the walk with fault = 1 and paddr = 0, whatever the value of bit 7. No table read is issued.
- R5: A directory entry with bit 0 = 1 and bit 7 = 1 ends the walk with no table read. The result is paddr = {pde[31:22], va[21:0]}, and directory entry bits 21:1 have no effect on it.
- R6: A directory entry with bit 0 = 1 and bit 7 = 0 starts a table read at {pde[31:12], va[21:12], 2'b00} in the cycle after its response.
- R7: A table entry with bit 0 = 1 gives paddr = {pte[31:12], va[11:0]} and fault = 0. A table entry with bit 0 = 0 gives fault = 1 and paddr = 0.
- R8: done is 1 for exactly one cycle, in the cycle after the final response, and mem_rd_valid is 0 during that cycle. req_ready is 1 again in the following cycle.
- R9: A request is accepted only while req_ready is 1. A req_valid raised during a walk does not change the address being read or the result.
- R10: A mem_rsp_valid with no read outstanding is ignored: it starts no read and raises no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| base_addr | input | 32 | Directory base register value |
| req_ready | output | 1 | Walker idle, request accepted |
| mem_rd_valid | output | 1 | Memory word read pending |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry returned by memory |
| done | output | 1 | One-cycle walk completion pulse |
| fault | output | 1 | Walk ended on a non-present entry |
| paddr | output | 32 | Translated physical address, zero on fault |

## Verification
The bench sends large-page entries whose middle bits are set. A walker that took 20 frame bits for a large page would return a corrupted offset. A non-present entry that also has its size flag set is tested too, because a design that checked size before presence would report a mapping where it should fault. Base bits 11:0 are set and the maximum indices are used, so a design that misplaced the index or failed to drop the low base bits would miss the expected entry address. Held requests, long response stalls and stray responses while idle are also driven; they expose a walker that samples a new address in mid-walk or advances without a valid response.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int unsigned PW_ADDR_W  = 32;
  localparam int unsigned PW_OFF_W   = 12;
  localparam int unsigned PW_IDX_W   = 10;
  localparam int unsigned PW_PRES_B  = 0;
  localparam int unsigned PW_SIZE_B  = 7;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_READ_PDE = 2'd1,
    ST_READ_PTE = 2'd2,
    ST_DONE     = 2'd3
  } pw_state_e;
endpackage

// File: rtl/pw_addr.sv
module pw_addr #(
  parameter int unsigned AW = pw_pkg::PW_ADDR_W,
  parameter int unsigned OW = pw_pkg::PW_OFF_W,
  parameter int unsigned IW = pw_pkg::PW_IDX_W
) (
  input  logic [AW-1:0] vaddr,
  input  logic [AW-1:0] dir_base,
  input  logic [AW-1:0] tbl_base,
  input  logic [AW-1:0] entry,
  output logic [AW-1:0] pde_addr,
  output logic [AW-1:0] pte_addr,
  output logic [AW-1:0] large_pa,
  output logic [AW-1:0] small_pa
);
  localparam int unsigned SHW   = OW - IW;
  localparam int unsigned LOW   = OW + IW;
  localparam int unsigned LFRW  = AW - LOW;

  always_comb begin
    pde_addr = {dir_base[AW-1:OW], vaddr[AW-1 -: IW], {SHW{1'b0}}};
    pte_addr = {tbl_base[AW-1:OW], vaddr[LOW-1 -: IW], {SHW{1'b0}}};
    large_pa = {entry[AW-1 -: LFRW], vaddr[LOW-1:0]};
    small_pa = {entry[AW-1:OW], vaddr[OW-1:0]};
  end
endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import pw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  logic      rsp_valid,
  input  logic      rsp_present,
  input  logic      rsp_large,
  output pw_state_e state,
  output logic      ld_req,
  output logic      ld_tbl,
  output logic      ld_res,
  output logic      res_fault,
  output logic      res_large
);
  pw_state_e nxt;

  always_comb begin
    nxt       = state;
    ld_req    = 1'b0;
    ld_tbl    = 1'b0;
    ld_res    = 1'b0;
    res_fault = 1'b0;
    res_large = 1'b0;
    case (state)
      ST_IDLE: begin
        if (req_valid) begin
          ld_req = 1'b1;
          nxt    = ST_READ_PDE;
        end
      end
      ST_READ_PDE: begin
        if (rsp_valid) begin
          if (!rsp_present) begin
            ld_res    = 1'b1;
            res_fault = 1'b1;
            nxt       = ST_DONE;
          end else if (rsp_large) begin
            ld_res    = 1'b1;
            res_large = 1'b1;
            nxt       = ST_DONE;
          end else begin
            ld_tbl = 1'b1;
            nxt    = ST_READ_PTE;
          end
        end
      end
      ST_READ_PTE: begin
        if (rsp_valid) begin
          ld_res    = 1'b1;
          res_fault = !rsp_present;
          nxt       = ST_DONE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/page_walker.sv
module page_walker
  import pw_pkg::*;
#(
  parameter int unsigned AW     = PW_ADDR_W,
  parameter int unsigned OW     = PW_OFF_W,
  parameter int unsigned IW     = PW_IDX_W,
  parameter int unsigned PRES_B = PW_PRES_B,
  parameter int unsigned SIZE_B = PW_SIZE_B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_vaddr,
  input  logic [AW-1:0] base_addr,
  output logic          req_ready,
  output logic          mem_rd_valid,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data,
  output logic          done,
  output logic          fault,
  output logic [AW-1:0] paddr
);
  localparam int unsigned LOW = OW + IW;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pw_state_e     state;
  logic          ld_req, ld_tbl, ld_res, res_fault, res_large;
  logic [AW-1:0] va_q, base_q, tbl_q, paddr_q;
  logic          fault_q;
  logic [AW-1:0] pde_addr, pte_addr, large_pa, small_pa, res_pa;

  pw_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid  (req_valid),
    .rsp_valid  (mem_rsp_valid),
    .rsp_present(mem_rsp_data[PRES_B]),
    .rsp_large  (mem_rsp_data[SIZE_B]),
    .state      (state),
    .ld_req     (ld_req),
    .ld_tbl     (ld_tbl),
    .ld_res     (ld_res),
    .res_fault  (res_fault),
    .res_large  (res_large)
  );

  pw_addr #(.AW(AW), .OW(OW), .IW(IW)) u_addr (
    .vaddr   (va_q),
    .dir_base(base_q),
    .tbl_base(tbl_q),
    .entry   (mem_rsp_data),
    .pde_addr(pde_addr),
    .pte_addr(pte_addr),
    .large_pa(large_pa),
    .small_pa(small_pa)
  );

  always_comb begin
    if (res_fault)      res_pa = '0;
    else if (res_large) res_pa = large_pa;
    else                res_pa = small_pa;
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      va_q   <= '0;
      base_q <= '0;
    end else if (ld_req) begin
      va_q   <= req_vaddr;
      base_q <= base_addr;
    end
  end

  // page-table base, enabled on a small-page directory entry
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  tbl_q <= '0;
    else if (ld_tbl) tbl_q <= mem_rsp_data;
  end

  // result, enabled on the final response
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      paddr_q <= '0;
      fault_q <= 1'b0;
    end else if (ld_res) begin
      paddr_q <= res_pa;
      fault_q <= res_fault;
    end
  end

  assign req_ready    = (state == ST_IDLE);
  assign mem_rd_valid = (state == ST_READ_PDE) || (state == ST_READ_PTE);
  assign mem_rd_addr  = (state == ST_READ_PTE) ? pte_addr : pde_addr;
  assign done         = (state == ST_DONE);
  assign fault        = fault_q;
  assign paddr        = paddr_q;

  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_rd_valid && !mem_rsp_valid) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R3

  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && fault) |-> (paddr == '0)); // R4

  AST_LARGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((state == ST_READ_PDE) && mem_rsp_valid && mem_rsp_data[PRES_B] && mem_rsp_data[SIZE_B])
    |=> (done && !fault && (paddr[LOW-1:0] == va_q[LOW-1:0]))); // R5

  AST_SMALL_OFFSET: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((state == ST_READ_PTE) && mem_rsp_valid && mem_rsp_data[PRES_B])
    |=> (done && !fault && (paddr[OW-1:0] == va_q[OW-1:0]))); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> (!done && req_ready)); // R8

  AST_DONE_NO_READ: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> !mem_rd_valid); // R8

  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_ready && !req_valid) |=> (req_ready && !mem_rd_valid)); // R10
endmodule

// File: tb/test_page_walker.sv
module test_page_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_vaddr, base_addr;
  logic        req_ready, mem_rd_valid;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        done, fault;
  logic [31:0] paddr;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  page_walker i_page_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .base_addr(base_addr), .req_ready(req_ready), .mem_rd_valid(mem_rd_valid),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault), .paddr(paddr)
  );

  typedef struct packed {
    logic [31:0] va;
    logic [31:0] base;
    logic [31:0] pde_a;
    logic [31:0] pde;
    logic [31:0] pte_a;
    logic [31:0] pte;
    logic [31:0] pa;
    logic [3:0]  wt;
    logic        flt;
    logic        two;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h0040_1234, 32'h0001_0000, 32'h0001_0004, 32'h0002_0001, 32'h0002_0004, 32'h0ABC_D001, 32'h0ABC_D234, 4'd0, 1'b0, 1'b1},
    '{32'h8123_4567, 32'h0001_0000, 32'h0001_0810, 32'hC000_0081, 32'h0,         32'h0,         32'hC023_4567, 4'd2, 1'b0, 1'b0},
    '{32'h8123_4567, 32'h0001_0ABC, 32'h0001_0810, 32'hC03F_F081, 32'h0,         32'h0,         32'hC023_4567, 4'd0, 1'b0, 1'b0},
    '{32'h0040_1234, 32'h0001_0000, 32'h0001_0004, 32'h0002_0000, 32'h0,         32'h0,         32'h0,         4'd1, 1'b1, 1'b0},
    '{32'h0040_1234, 32'h0001_0000, 32'h0001_0004, 32'h0002_0001, 32'h0002_0004, 32'h0ABC_D000, 32'h0,         4'd3, 1'b1, 1'b1},
    '{32'h8123_4567, 32'h0001_0000, 32'h0001_0810, 32'hC000_0080, 32'h0,         32'h0,         32'h0,         4'd0, 1'b1, 1'b0},
    '{32'hFFFF_FFFF, 32'h0001_0000, 32'h0001_0FFC, 32'h1234_5F7F, 32'h1234_5FFC, 32'h8765_4FFF, 32'h8765_4FFF, 4'd5, 1'b0, 1'b1},
    '{32'h0000_0000, 32'hFFFF_F123, 32'hFFFF_F000, 32'h0000_0001, 32'h0000_0000, 32'h0000_0001, 32'h0000_0000, 4'd0, 1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // answer the pending read after wt stall cycles; entered at a negedge with the read active
  task automatic respond(input int wt, input logic [31:0] data, input logic [31:0] a);
    for (int i = 0; i < wt; i++) begin
      @(negedge clk);
      chk(mem_rd_valid === 1'b1 && mem_rd_addr === a, "R3 read held", mem_rd_addr, a);
    end
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = data;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'hDEAD_BEEF;
  endtask

  task automatic run_walk(input vec_t v);
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = v.va;
    base_addr = v.base;
    @(negedge clk);
    req_valid = 1'b0;
    base_addr = ~v.base;
    req_vaddr = ~v.va;
    chk(mem_rd_valid === 1'b1 && mem_rd_addr === v.pde_a, "R2 directory address", mem_rd_addr, v.pde_a);
    respond(v.wt, v.pde, v.pde_a);
    if (v.two) begin
      chk(mem_rd_valid === 1'b1 && mem_rd_addr === v.pte_a, "R6 table address", mem_rd_addr, v.pte_a);
      respond(v.wt, v.pte, v.pte_a);
    end
    chk(done === 1'b1 && mem_rd_valid === 1'b0, "R8 done after final response", {30'd0, done, mem_rd_valid}, 32'h2);
    if (v.flt)
      chk(fault === 1'b1 && paddr === 32'h0, v.two ? "R7 table fault" : "R4 directory fault", paddr, 32'h0);
    else
      chk(fault === 1'b0 && paddr === v.pa, v.two ? "R7 small page address" : "R5 large page address", paddr, v.pa);
    @(negedge clk);
    chk(done === 1'b0 && req_ready === 1'b1, "R8 single pulse, ready again", {30'd0, done, req_ready}, 32'h1);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_vaddr = '0;
    base_addr = '0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && mem_rd_valid === 1'b0 && done === 1'b0 && fault === 1'b0,
        "R1 in reset", {28'd0, req_ready, mem_rd_valid, done, fault}, 32'h8);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && mem_rd_valid === 1'b0 && done === 1'b0 && fault === 1'b0,
        "R1 after reset", {28'd0, req_ready, mem_rd_valid, done, fault}, 32'h8);

    for (int k = 0; k < NV; k++) run_walk(VECS[k]);

    // R10: stray response while idle
    @(negedge clk);
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = 32'hC000_0081;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk(mem_rd_valid === 1'b0 && done === 1'b0 && req_ready === 1'b1, "R10 stray response ignored",
        {29'd0, mem_rd_valid, done, req_ready}, 32'h1);

    // R9: new request held high during a walk is not taken
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = 32'h0040_1234;
    base_addr = 32'h0001_0000;
    @(negedge clk);
    req_vaddr = 32'h8123_4567;
    base_addr = 32'h0002_0000;
    chk(req_ready === 1'b0, "R9 busy during walk", {31'd0, req_ready}, 32'h0);
    repeat (2) @(negedge clk);
    chk(mem_rd_addr === 32'h0001_0004, "R9 directory address kept", mem_rd_addr, 32'h0001_0004);
    respond(0, 32'h0002_0001, 32'h0001_0004);
    chk(mem_rd_addr === 32'h0002_0004, "R9 table address kept", mem_rd_addr, 32'h0002_0004);
    respond(1, 32'h0ABC_D001, 32'h0002_0004);
    req_valid = 1'b0;
    chk(done === 1'b1 && paddr === 32'h0ABC_D234, "R9 result of first request", paddr, 32'h0ABC_D234);
    @(negedge clk);

    // R1: reset in mid-walk returns to idle
    @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b1 && mem_rd_valid === 1'b0, "R1 reset during walk",
        {30'd0, req_ready, mem_rd_valid}, 32'h2);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_walk(VECS[0]);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule